// File: doc/BRIEF.md
# Block-Averaging Frequency Estimator

This block takes a stream of timestamp records from a continuous timestamping counter. Each record pairs an edge count with the time at which that edge was seen. It groups the records into blocks of M consecutive entries. The first M/2 records of a block form the leading half and the remaining M/2 form the trailing half.

For each half the block accumulates the sum of the time values and the sum of the edge counts. When the last record of the block arrives, it produces two results:

- the trailing time-sum minus the leading time-sum;
- the trailing count-sum minus the leading count-sum.

It raises a one-cycle completion strobe with these results. Both halves hold the same number of records, so the 1/(M/2) averaging factor cancels. The ratio of the time difference to the count difference is therefore the averaged period, and its inverse is the frequency. Software or a later divider forms that ratio.

Averaging each half before differencing keeps roughly square-root-of-M noise reduction. Chaining differences of adjacent records would keep only the two endpoints.

Edge counts need not be evenly spaced. Counts are summed exactly like times, so irregular record spacing is handled.

A synchronous clear abandons a partial block, so the next block can be aligned to a chosen start.

Top module: `bafe_estimator`

## Requirements
- R1: After reset, `blk_done` is 0 and both `time_delta` and `count_delta` are 0.
- R2: Valid records are numbered from 0 within a block. Records 0 to M/2-1 count toward the leading half and records M/2 to M-1 count toward the trailing half. Only cycles with `rec_valid` high advance the numbering.
- R3: `blk_done` is high for exactly one cycle, in the cycle after the clock edge that accepts record M-1. It is low at all other times.
- R4: On that strobe, `time_delta` equals the sum of the trailing-half times minus the sum of the leading-half times. It is a two's complement value of TIME_W + ceil(log2(M/2+1)) + 1 bits.
- R5: On that strobe, `count_delta` equals the sum of the trailing-half counts minus the sum of the leading-half counts. It is a two's complement value of CNT_W + ceil(log2(M/2+1)) + 1 bits. Counts need not be evenly spaced.
- R6: The record accepted after record M-1 is record 0 of a new block, and no earlier record contributes to that new block.
- R7: A cycle with `blk_clear` high discards the partial block, and any record presented in that same cycle is dropped. The next valid record becomes record 0. The clear does not change the held results.
- R8: No sum wraps, even with every time or count at its all-ones value. The results reach plus or minus (M/2)·(2^W−1) exactly.
- R9: `time_delta` and `count_delta` change only in a cycle where `blk_done` is high, and they hold their values otherwise.
- R10: Cycles with `rec_valid` low do not affect any sum or the record numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_clear | input | 1 | Abandon the current partial block |
| rec_valid | input | 1 | A record is presented this cycle |
| rec_time | input | TIME_W | Timestamp of the record |
| rec_count | input | CNT_W | Edge count of the record |
| time_delta | output | TIME_W+ceil(log2(M/2+1))+1 | Trailing time-sum minus leading time-sum |
| count_delta | output | CNT_W+ceil(log2(M/2+1))+1 | Trailing count-sum minus leading count-sum |
| blk_done | output | 1 | One-cycle strobe marking new results |

## Verification
The bench builds the block with M = 8, TIME_W = 48 and CNT_W = 32. The short block lets many complete blocks, back-to-back runs and mid-block clears fit in a short run. The full 48-bit time width keeps the all-ones extremes in reach, where the result needs every guard bit of the sum. Idle gaps are mixed into the record stream. A behavioural model that queues records is compared with the outputs on every cycle.

// File: rtl/bafe_pkg.sv
package bafe_pkg;

   typedef enum logic {
      HALF_LEAD  = 1'b0,
      HALF_TRAIL = 1'b1
   } half_e;

   // control word shared by the sequencer and every accumulator
   typedef struct packed {
      logic  add;    // accept a record this cycle
      half_e side;   // half it belongs to
      logic  close;  // record is the last of the block
      logic  wipe;   // abandon the block
   } acc_ctl_t;

   function automatic int sum_width(input int w, input int n);
      return w + $clog2(n + 1);
   endfunction

endpackage

// File: rtl/bafe_sequencer.sv
module bafe_sequencer
   import bafe_pkg::*;
#(
   parameter int M = 200
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     blk_clear,
   input  logic     rec_valid,
   output acc_ctl_t ctl,
   output logic     done
);
   localparam int HALF  = M / 2;
   localparam int IDX_W = (M > 2) ? $clog2(M) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(M - 1);
   localparam logic [IDX_W-1:0] HALF_IDX  = IDX_W'(HALF);

   logic [IDX_W-1:0] rec_idx;
   logic             done_q;

   always_comb begin
      ctl.wipe  = blk_clear;
      ctl.add   = rec_valid & ~blk_clear;
      ctl.side  = (rec_idx >= HALF_IDX) ? HALF_TRAIL : HALF_LEAD;
      ctl.close = ctl.add & (rec_idx == LAST_IDX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_idx <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= ctl.close;
         if (ctl.wipe)
            rec_idx <= '0;
         else if (ctl.close)
            rec_idx <= '0;
         else if (ctl.add)
            rec_idx <= rec_idx + 1'b1;
      end
   end

   assign done = done_q;

   // R2: the record index never leaves the block
   p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rec_idx <= LAST_IDX);

   // R3: the strobe never lasts two cycles
   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: a clear restarts numbering at record 0
   p_clear_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      blk_clear |=> (rec_idx == '0));

   // R10: idle cycles leave the numbering alone
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_valid && !blk_clear) |=> $stable(rec_idx));

endmodule

// File: rtl/bafe_half_acc.sv
module bafe_half_acc
   import bafe_pkg::*;
#(
   parameter int W        = 48,
   parameter int HALF     = 100,
   parameter bit DIFF_ACC = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  acc_ctl_t                  ctl,
   input  logic [W-1:0]              value,
   output logic signed [sum_width(W, HALF):0] delta
);
   localparam int AW = sum_width(W, HALF);

   logic signed [AW:0] val_s;
   assign val_s = $signed({{(AW + 1 - W){1'b0}}, value});

   generate
      if (DIFF_ACC) begin : g_single
         // one signed running difference: trailing adds, leading subtracts
         logic signed [AW:0] run;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run   <= '0;
               delta <= '0;
            end else if (ctl.wipe) begin
               run <= '0;
            end else if (ctl.close) begin
               delta <= run + val_s;
               run   <= '0;
            end else if (ctl.add) begin
               if (ctl.side == HALF_TRAIL)
                  run <= run + val_s;
               else
                  run <= run - val_s;
            end
         end

         // R6: a finished block leaves nothing behind
         p_close_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl.close && !ctl.wipe) |=> (run == '0));

         // R7: a clear empties the running difference
         p_wipe_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ctl.wipe |=> (run == '0));
      end else begin : g_pair
         // two unsigned half sums, differenced once per block
         logic [AW-1:0] sum_lead;
         logic [AW-1:0] sum_trail;
         logic [AW-1:0] trail_next;

         assign trail_next = sum_trail + AW'(value);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sum_lead  <= '0;
               sum_trail <= '0;
               delta     <= '0;
            end else if (ctl.wipe) begin
               sum_lead  <= '0;
               sum_trail <= '0;
            end else if (ctl.close) begin
               delta     <= $signed({1'b0, trail_next}) - $signed({1'b0, sum_lead});
               sum_lead  <= '0;
               sum_trail <= '0;
            end else if (ctl.add) begin
               if (ctl.side == HALF_TRAIL)
                  sum_trail <= trail_next;
               else
                  sum_lead <= sum_lead + AW'(value);
            end
         end

         // R8: the leading sum only grows while it is being filled
         p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl.add && !ctl.close && !ctl.wipe && ctl.side == HALF_LEAD)
            |=> (sum_lead >= $past(sum_lead)));

         // R8: the trailing sum only grows while it is being filled
         p_no_overflow_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl.add && !ctl.close && !ctl.wipe && ctl.side == HALF_TRAIL)
            |=> (sum_trail >= $past(sum_trail)));

         // R7: a clear empties both sums
         p_wipe_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ctl.wipe |=> (sum_lead == '0 && sum_trail == '0));
      end
   endgenerate

endmodule

// File: rtl/bafe_estimator.sv
module bafe_estimator
   import bafe_pkg::*;
#(
   parameter int M        = 200,
   parameter int TIME_W   = 48,
   parameter int CNT_W    = 48,
   parameter bit DIFF_ACC = 1'b0
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   blk_clear,
   input  logic                                   rec_valid,
   input  logic [TIME_W-1:0]                      rec_time,
   input  logic [CNT_W-1:0]                       rec_count,
   output logic [sum_width(TIME_W, M / 2):0]      time_delta,
   output logic [sum_width(CNT_W, M / 2):0]       count_delta,
   output logic                                   blk_done
);
   localparam int HALF = M / 2;
   localparam int TAW  = sum_width(TIME_W, HALF);
   localparam int CAW  = sum_width(CNT_W, HALF);

   generate
      if (M < 2 || (M % 2) != 0) begin : g_bad_m
         $error("bafe_estimator: M must be even and at least 2");
      end
      if (TIME_W < 1 || CNT_W < 1) begin : g_bad_w
         $error("bafe_estimator: field widths must be positive");
      end
   endgenerate

   acc_ctl_t ctl;
   logic signed [TAW:0] t_delta;
   logic signed [CAW:0] c_delta;

   bafe_sequencer #(.M(M)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_clear (blk_clear),
      .rec_valid (rec_valid),
      .ctl       (ctl),
      .done      (blk_done)
   );

   bafe_half_acc #(.W(TIME_W), .HALF(HALF), .DIFF_ACC(DIFF_ACC)) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl),
      .value (rec_time),
      .delta (t_delta)
   );

   bafe_half_acc #(.W(CNT_W), .HALF(HALF), .DIFF_ACC(DIFF_ACC)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl),
      .value (rec_count),
      .delta (c_delta)
   );

   assign time_delta  = t_delta;
   assign count_delta = c_delta;

   // R9: results move only together with the strobe
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_done |-> ($stable(time_delta) && $stable(count_delta)));

   // R7: a clear never produces a strobe
   p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      blk_clear |=> !blk_done);

endmodule

// File: tb/sim_bafe_estimator.sv
module sim_bafe_estimator;
   localparam int M      = 8;
   localparam int HALF   = M / 2;
   localparam int TIME_W = 48;
   localparam int CNT_W  = 32;
   localparam int TDW    = TIME_W + $clog2(HALF + 1) + 1;
   localparam int CDW    = CNT_W + $clog2(HALF + 1) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic blk_clear = 1'b0;
   logic rec_valid = 1'b0;
   logic [TIME_W-1:0] rec_time = '0;
   logic [CNT_W-1:0]  rec_count = '0;
   logic [TDW-1:0]    time_delta;
   logic [CDW-1:0]    count_delta;
   logic              blk_done;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   bafe_estimator #(.M(M), .TIME_W(TIME_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .blk_clear(blk_clear), .rec_valid(rec_valid),
      .rec_time(rec_time), .rec_count(rec_count),
      .time_delta(time_delta), .count_delta(count_delta), .blk_done(blk_done)
   );

   // behavioural reference: a queue of accepted records per block
   longint q_time[$];
   longint q_cnt[$];
   longint exp_t = 0;
   longint exp_c = 0;
   bit     exp_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q_time.delete(); q_cnt.delete();
         exp_t = 0; exp_c = 0; exp_done = 0;
      end else begin
         exp_done = 0;
         if (blk_clear) begin
            q_time.delete(); q_cnt.delete();
         end else if (rec_valid) begin
            q_time.push_back(longint'(rec_time));
            q_cnt.push_back(longint'(rec_count));
            if (q_time.size() == M) begin
               exp_t = 0; exp_c = 0;
               for (int i = 0; i < M; i++) begin
                  if (i < HALF) begin
                     exp_t -= q_time[i]; exp_c -= q_cnt[i];
                  end else begin
                     exp_t += q_time[i]; exp_c += q_cnt[i];
                  end
               end
               exp_done = 1;
               q_time.delete(); q_cnt.delete();
            end
         end
      end
   end

   function automatic longint act_t();
      logic signed [TDW-1:0] s;
      s = time_delta;
      return longint'(s);
   endfunction

   function automatic longint act_c();
      logic signed [CDW-1:0] s;
      s = count_delta;
      return longint'(s);
   endfunction

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // every-cycle comparison, sampled away from the edge
   always @(posedge clk) begin
      cycles++;
      #2;
      check("R3", "blk_done", longint'(blk_done), longint'(exp_done));
      check("R4", "time_delta", act_t(), exp_t);
      check("R5", "count_delta", act_c(), exp_c);
   end

   task automatic send(input longint t, input longint c);
      @(negedge clk);
      rec_valid = 1'b1;
      rec_time  = TIME_W'(t);
      rec_count = CNT_W'(c);
      @(negedge clk);
      rec_valid = 1'b0;
   endtask

   task automatic send_noidle(input longint t, input longint c);
      @(negedge clk);
      rec_valid = 1'b1;
      rec_time  = TIME_W'(t);
      rec_count = CNT_W'(c);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rec_valid = 1'b0;
      end
   endtask

   task automatic wait_result();
      @(posedge clk);
      #2;
   endtask

   longint all1;

   initial begin
      all1 = (longint'(1) << TIME_W) - 1;
      idle(3);
      rst_n = 1'b1;
      wait_result();
      // R1: reset state
      check("R1", "done after reset", longint'(blk_done), 0);
      check("R1", "time after reset", act_t(), 0);
      check("R1", "count after reset", act_c(), 0);

      // R2 R4 R5 R10: uneven counts, idle gaps between records
      begin
         longint cs[8] = '{3, 7, 12, 20, 25, 31, 40, 41};
         for (int i = 0; i < M; i++) begin
            send(100 * (i + 1), cs[i]);
            idle(i % 3);
         end
      end
      // last record accepted at the edge before the send task's closing negedge
      check("R4", "time 1..8 block", act_t(), 1600);
      check("R5", "uneven count block", act_c(), 95);
      idle(4);
      check("R9", "time held", act_t(), 1600);
      check("R9", "count held", act_c(), 95);
      check("R10", "no strobe while idle", longint'(blk_done), 0);

      // R6: back-to-back blocks with no idle cycles
      for (int i = 0; i < M; i++) send_noidle(1000 - 10 * i, 2 * i);
      for (int i = 0; i < M; i++) send_noidle(5, 10 + i);
      @(negedge clk); rec_valid = 1'b0;
      check("R6", "second block time", act_t(), 0);
      check("R6", "second block count", act_c(), 16);

      // R3: no strobe after only M-1 records
      for (int i = 0; i < M - 1; i++) send(50 + i, i);
      idle(2);
      check("R3", "no strobe at M-1", longint'(blk_done), 0);
      check("R9", "time unchanged mid block", act_t(), 0);

      // R7: clear with a record present, then a fresh block
      @(negedge clk);
      blk_clear = 1'b1; rec_valid = 1'b1; rec_time = 48'd999999; rec_count = 32'd77;
      @(negedge clk);
      blk_clear = 1'b0; rec_valid = 1'b0;
      check("R7", "clear keeps time", act_t(), 0);
      check("R7", "clear keeps count", act_c(), 16);
      for (int i = 0; i < M; i++) send(i < HALF ? 7 : 3, i < HALF ? 1 : 2);
      check("R7", "fresh block time", act_t(), -16);
      check("R7", "fresh block count", act_c(), 4);

      // R8: extremes in both directions
      for (int i = 0; i < M; i++) send(i < HALF ? 0 : all1, i < HALF ? 0 : 32'hFFFF_FFFF);
      check("R8", "max positive time", act_t(), HALF * all1);
      check("R8", "max positive count", act_c(), HALF * longint'(32'hFFFF_FFFF));
      for (int i = 0; i < M; i++) send(i < HALF ? all1 : 0, i < HALF ? 32'hFFFF_FFFF : 0);
      check("R8", "max negative time", act_t(), -HALF * all1);
      check("R8", "max negative count", act_c(), -HALF * longint'(32'hFFFF_FFFF));

      idle(5);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule